// File: doc/BRIEF.md
# Per-Word Miss Status Register with Write Merge

This block tracks one outstanding cache-block miss using a fixed slot for every processor word of the block, rather than a list of targets. With the default 32-byte block and 32-bit words there are eight slots, selected directly by the word index of the request. A read miss fills the slot for its word with a destination register number and a format descriptor: access width, byte position and signedness. A store to the missing block goes into a single line-wide write buffer, and a per-word write mask records it.

Further misses to the same block merge into the entry only when they touch a word that is still free for their kind of access. A second read to a word that already has a read slot is refused with a block indication, and so is a second store to a word that is already masked. When the fill arrives, the block produces the completed line. In it, masked words come from the write buffer and all other words come from the fill data. In the same cycle it produces one completion per waiting read, with that read's word shifted and extended as its format asks. The fill clears the entry, so the next miss starts from empty.

Top module: `word_slot_mshr`

## Requirements
- R1: A read miss (`miss_is_write`=0) to a word whose slot is free is accepted: `miss_ack` is 1 and `miss_block` is 0 in the cycle after the request. The slot used is the one numbered by `miss_word`.
- R2: A read miss to a word whose slot is already occupied gives `miss_block`=1 in the next cycle. The slot keeps its original destination and format, and these are reported at fill.
- R3: A write miss to an unmasked word stores `miss_wdata` and sets that word's mask bit. A write miss to a masked word gives `miss_block`=1, and the first stored data is kept.
- R4: Each cycle with `miss_valid`=1 yields exactly one of `miss_ack` or `miss_block` one cycle later. With no request, both are 0. A miss presented in the same cycle as `fill_valid` is blocked and leaves no trace.
- R5: `line_valid` is 1 in the cycle after `fill_valid`. Word i of `line_data` (bits 32i+31..32i) is the buffered store data if word i is masked, and word i of `fill_line` otherwise.
- R6: In the cycle `line_valid` is 1, `rd_valid[i]` is 1 exactly for the occupied read slots. `rd_dest` field i holds that slot's destination. `rd_data` word i is the merged line word shifted right by 8×offset. Size 0 keeps 8 bits, size 1 keeps 16 bits, and sizes 2 and 3 keep all 32 bits. A kept field is sign-extended when the signed flag is 1 and zero-extended when it is 0.
- R7: A fill empties all slots and mask bits. After it, a miss to a previously occupied word is accepted, and a later fill with no intervening misses returns `fill_line` unchanged with `rd_valid`=0.
- R8: After synchronous reset, the entry is empty and `miss_ack`, `miss_block`, `line_valid`, `rd_valid`, `line_data` and `rd_data` are all 0.
- R9: `rd_valid` is 0 in every cycle in which `line_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request to this block |
| miss_is_write | input | 1 | 1 for a store, 0 for a load |
| miss_word | input | 3 | Word index within the block |
| miss_dest | input | 5 | Destination register of a load |
| miss_size | input | 2 | Load width: 0 byte, 1 half, 2/3 word |
| miss_off | input | 2 | Byte offset within the word |
| miss_signed | input | 1 | Sign-extend the loaded field |
| miss_wdata | input | 32 | Store data |
| miss_ack | output | 1 | Previous request merged |
| miss_block | output | 1 | Previous request refused |
| fill_valid | input | 1 | Fill data present |
| fill_line | input | 256 | Fill data, word 0 in the low bits |
| line_valid | output | 1 | Completed line present |
| line_data | output | 256 | Line with stores merged |
| rd_valid | output | 8 | Per-slot load completion |
| rd_dest | output | 40 | Per-slot destination, 5 bits each |
| rd_data | output | 256 | Per-slot formatted load data |

## Verification
Every result of this block is due exactly one clock after its cause. The accept or block decision follows one cycle after the miss request. The line and the load completions follow one cycle after the fill. The emptied state shows up in the decision for the first miss after the fill. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares all outputs on the next falling edge, after the single register stage has captured its result. Directed sequences cover the conflict, merge and concurrency cases, and a random phase then mixes loads, stores and fills.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } fmt_size_e;
endpackage

// File: rtl/mshr_slot_file.sv
module mshr_slot_file
  import mshr_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DEST_W = 5,
  parameter int OFF_W  = 2,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DEST_W-1:0]       wr_dest,
  input  fmt_size_e               wr_size,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic                    wr_signed,
  output logic [WORDS-1:0]        occ,
  output logic [WORDS*DEST_W-1:0] dest_flat,
  output logic [WORDS*2-1:0]      size_flat,
  output logic [WORDS*OFF_W-1:0]  off_flat,
  output logic [WORDS-1:0]        sgn
);
  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        occ[i] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        occ[i] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i)) begin
        dest_flat[i*DEST_W +: DEST_W] <= wr_dest;
        size_flat[i*2 +: 2]           <= wr_size;
        off_flat[i*OFF_W +: OFF_W]    <= wr_off;
        sgn[i]                        <= wr_signed;
      end
    end
  end

  // R1: an accepted load marks its own slot
  a_r1_slot_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> occ[$past(wr_idx)]);
endmodule

// File: rtl/mshr_write_merge.sv
module mshr_write_merge #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LINE_W-1:0] fill_line,
  output logic [WORDS-1:0]  mask,
  output logic [LINE_W-1:0] merged
);
  logic [WORD_W-1:0] wbuf [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) wbuf[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[wr_idx] <= 1'b1;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_merge
    assign merged[i*WORD_W +: WORD_W] = mask[i] ? wbuf[i] : fill_line[i*WORD_W +: WORD_W];
  end

  // R3: an accepted store marks its word in the mask
  a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/mshr_word_format.sv
module mshr_word_format
  import mshr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  fmt_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sgn,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word >> {off, 3'b000};
    unique case (size)
      SZ_BYTE: result = {{(WORD_W-8){sgn & shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(WORD_W-16){sgn & shifted[15]}}, shifted[15:0]};
      default: result = shifted;
    endcase
  end
endmodule

// File: rtl/word_slot_mshr.sv
module word_slot_mshr
  import mshr_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int DEST_W = 5,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int OFF_W  = $clog2(WORD_W / 8),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic                    miss_is_write,
  input  logic [IDX_W-1:0]        miss_word,
  input  logic [DEST_W-1:0]       miss_dest,
  input  logic [1:0]              miss_size,
  input  logic [OFF_W-1:0]        miss_off,
  input  logic                    miss_signed,
  input  logic [WORD_W-1:0]       miss_wdata,
  output logic                    miss_ack,
  output logic                    miss_block,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  output logic                    line_valid,
  output logic [LINE_W-1:0]       line_data,
  output logic [WORDS-1:0]        rd_valid,
  output logic [WORDS*DEST_W-1:0] rd_dest,
  output logic [LINE_W-1:0]       rd_data
);
  logic [WORDS-1:0]        occ;
  logic [WORDS-1:0]        mask;
  logic [WORDS*DEST_W-1:0] dest_flat;
  logic [WORDS*2-1:0]      size_flat;
  logic [WORDS*OFF_W-1:0]  off_flat;
  logic [WORDS-1:0]        sgn;
  logic [LINE_W-1:0]       merged;
  logic [LINE_W-1:0]       formatted;
  logic                    conflict;
  logic                    take;

  assign conflict = miss_is_write ? mask[miss_word] : occ[miss_word];
  assign take     = miss_valid && !fill_valid && !conflict;

  mshr_slot_file #(.WORDS(WORDS), .DEST_W(DEST_W), .OFF_W(OFF_W)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .clear     (fill_valid),
    .wr_en     (take && !miss_is_write),
    .wr_idx    (miss_word),
    .wr_dest   (miss_dest),
    .wr_size   (fmt_size_e'(miss_size)),
    .wr_off    (miss_off),
    .wr_signed (miss_signed),
    .occ       (occ),
    .dest_flat (dest_flat),
    .size_flat (size_flat),
    .off_flat  (off_flat),
    .sgn       (sgn)
  );

  mshr_write_merge #(.WORDS(WORDS), .WORD_W(WORD_W)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .clear     (fill_valid),
    .wr_en     (take && miss_is_write),
    .wr_idx    (miss_word),
    .wr_data   (miss_wdata),
    .fill_line (fill_line),
    .mask      (mask),
    .merged    (merged)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_fmt
    mshr_word_format #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_fmt (
      .word   (merged[i*WORD_W +: WORD_W]),
      .size   (fmt_size_e'(size_flat[i*2 +: 2])),
      .off    (off_flat[i*OFF_W +: OFF_W]),
      .sgn    (sgn[i]),
      .result (formatted[i*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_ack   <= 1'b0;
      miss_block <= 1'b0;
      line_valid <= 1'b0;
      rd_valid   <= '0;
      line_data  <= '0;
      rd_dest    <= '0;
      rd_data    <= '0;
    end else begin
      miss_ack   <= take;
      miss_block <= miss_valid && !take;
      line_valid <= fill_valid;
      rd_valid   <= fill_valid ? occ : '0;
      if (fill_valid) begin
        line_data <= merged;
        rd_dest   <= dest_flat;
        rd_data   <= formatted;
      end
    end
  end

  // R2: load to an occupied slot is refused
  a_r2_read_conflict: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_is_write && !fill_valid && occ[miss_word]) |=> miss_block);
  // R3: store to a masked word is refused
  a_r3_write_conflict: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_is_write && !fill_valid && mask[miss_word]) |=> miss_block);
  // R4: never both answers
  a_r4_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(miss_ack && miss_block));
  // R4: a miss during a fill is refused
  a_r4_fill_collision: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && fill_valid) |=> miss_block);
  // R5: line follows fill by one cycle
  a_r5_line_timing: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> line_valid);
  // R7: fill empties the entry
  a_r7_cleared: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (occ == '0 && mask == '0));
  // R9: completions only with the line
  a_r9_rd_with_line: assert property (@(posedge clk) disable iff (rst)
    (rd_valid != '0) |-> line_valid);
endmodule

// File: tb/word_slot_mshr_test.sv
module word_slot_mshr_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         miss_valid = 0, miss_is_write = 0, miss_signed = 0;
  logic [2:0]   miss_word = 0;
  logic [4:0]   miss_dest = 0;
  logic [1:0]   miss_size = 0, miss_off = 0;
  logic [31:0]  miss_wdata = 0;
  logic         fill_valid = 0;
  logic [255:0] fill_line = 0;
  logic         miss_ack, miss_block, line_valid;
  logic [255:0] line_data, rd_data;
  logic [7:0]   rd_valid;
  logic [39:0]  rd_dest;

  int checks = 0;
  int errors = 0;

  word_slot_mshr uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_is_write(miss_is_write),
    .miss_word(miss_word), .miss_dest(miss_dest), .miss_size(miss_size),
    .miss_off(miss_off), .miss_signed(miss_signed), .miss_wdata(miss_wdata),
    .miss_ack(miss_ack), .miss_block(miss_block), .fill_valid(fill_valid),
    .fill_line(fill_line), .line_valid(line_valid), .line_data(line_data),
    .rd_valid(rd_valid), .rd_dest(rd_dest), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  bit          m_occ [8];
  bit          m_mask[8];
  logic [4:0]  m_dest[8];
  logic [1:0]  m_size[8];
  logic [1:0]  m_off [8];
  bit          m_sgn [8];
  logic [31:0] m_buf [8];
  bit           e_ack, e_blk, e_lv;
  logic [7:0]   e_rv;
  logic [255:0] e_line;
  logic [31:0]  e_rd  [8];
  logic [4:0]   e_dest[8];

  function automatic logic [31:0] shape(logic [31:0] w, logic [1:0] sz, logic [1:0] off, bit s);
    logic [31:0] v;
    v = w >> (off * 8);
    if (sz == 2'd0) begin
      v = v & 32'hFF;
      if (s && v >= 32'h80) v = v - 32'h100;
    end else if (sz == 2'd1) begin
      v = v & 32'hFFFF;
      if (s && v >= 32'h8000) v = v - 32'h10000;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_ack = 0; e_blk = 0; e_lv = 0; e_rv = 0; e_line = 0;
      for (int i = 0; i < 8; i++) begin
        m_occ[i] = 0; m_mask[i] = 0; e_rd[i] = 0;
      end
    end else begin
      e_ack = 0; e_blk = 0; e_lv = fill_valid; e_rv = 0;
      if (miss_valid) begin
        if (fill_valid) e_blk = 1;
        else if (miss_is_write) begin
          if (m_mask[miss_word]) e_blk = 1;
          else begin e_ack = 1; m_mask[miss_word] = 1; m_buf[miss_word] = miss_wdata; end
        end else begin
          if (m_occ[miss_word]) e_blk = 1;
          else begin
            e_ack = 1; m_occ[miss_word] = 1; m_dest[miss_word] = miss_dest;
            m_size[miss_word] = miss_size; m_off[miss_word] = miss_off; m_sgn[miss_word] = miss_signed;
          end
        end
      end
      if (fill_valid) begin
        for (int i = 0; i < 8; i++) begin
          logic [31:0] w;
          w = m_mask[i] ? m_buf[i] : fill_line[i*32 +: 32];
          e_line[i*32 +: 32] = w;
          if (m_occ[i]) begin
            e_rv[i] = 1; e_dest[i] = m_dest[i];
            e_rd[i] = shape(w, m_size[i], m_off[i], m_sgn[i]);
          end
          m_occ[i] = 0; m_mask[i] = 0;
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    check(miss_ack == e_ack, "R1/R4 miss_ack", 256'(miss_ack), 256'(e_ack));
    check(miss_block == e_blk, "R2/R3/R4 miss_block", 256'(miss_block), 256'(e_blk));
    check(line_valid == e_lv, "R5 line_valid", 256'(line_valid), 256'(e_lv));
    check(rd_valid == e_rv, "R6/R9 rd_valid", 256'(rd_valid), 256'(e_rv));
    check(line_data == e_line, "R5 line_data", line_data, e_line);
    for (int i = 0; i < 8; i++) begin
      if (e_rv[i]) begin
        check(rd_dest[i*5 +: 5] == e_dest[i], "R6 rd_dest", 256'(rd_dest[i*5 +: 5]), 256'(e_dest[i]));
        check(rd_data[i*32 +: 32] == e_rd[i], "R6 rd_data", 256'(rd_data[i*32 +: 32]), 256'(e_rd[i]));
      end
    end
  end

  task automatic miss(bit wr, int w, int dest, int sz, int off, bit s, logic [31:0] d);
    @(negedge clk);
    miss_valid = 1; miss_is_write = wr; miss_word = 3'(w); miss_dest = 5'(dest);
    miss_size = 2'(sz); miss_off = 2'(off); miss_signed = s; miss_wdata = d;
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic fill(logic [255:0] l, bit with_miss);
    @(negedge clk);
    fill_valid = 1; fill_line = l;
    if (with_miss) begin miss_valid = 1; miss_is_write = 0; miss_word = 3'd6; end
    @(negedge clk);
    fill_valid = 0; miss_valid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [255:0] pat;
  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check(miss_ack == 0 && miss_block == 0 && line_valid == 0 && rd_valid == 0 && line_data == 0 && rd_data == 0,
          "R8 reset outputs", 256'(rd_valid), 256'(0));
    rst = 0;
    pat = {32'h8899AABB, 32'h11223344, 32'hF0E0D0C0, 32'h0000807F,
           32'hCAFEBABE, 32'h12345678, 32'h00FF80FF, 32'hDEADBEEF};
    // R1: loads to free slots with varied formats
    miss(0, 0, 3, 0, 1, 1, 0);
    check(miss_ack == 1, "R1 accept load", 256'(miss_ack), 256'(1));
    miss(0, 1, 4, 1, 2, 1, 0);
    miss(0, 4, 9, 0, 0, 0, 0);
    miss(0, 7, 31, 2, 0, 0, 0);
    miss(0, 3, 12, 1, 0, 1, 0);
    // R2: second load to word 3 refused
    miss(0, 3, 20, 2, 0, 0, 0);
    check(miss_block == 1, "R2 occupied slot blocks", 256'(miss_block), 256'(1));
    // R3: stores, then repeat store to word 5 refused
    miss(1, 3, 0, 0, 0, 0, 32'h0000F123);
    miss(1, 5, 0, 0, 0, 0, 32'hA5A5A5A5);
    miss(1, 5, 0, 0, 0, 0, 32'h5A5A5A5A);
    check(miss_block == 1, "R3 masked word blocks", 256'(miss_block), 256'(1));
    // R4, R5, R6: fill with colliding miss
    fill(pat, 1);
    check(line_valid == 1 && line_data[5*32 +: 32] == 32'hA5A5A5A5, "R5 merged store",
          256'(line_data[5*32 +: 32]), 256'(32'hA5A5A5A5));
    check(rd_data[3*32 +: 32] == 32'hFFFFF123, "R6 half signed from buffer",
          256'(rd_data[3*32 +: 32]), 256'(32'hFFFFF123));
    check(miss_block == 1, "R4 miss during fill", 256'(miss_block), 256'(1));
    // R7: entry empty after fill
    miss(0, 3, 7, 2, 0, 0, 0);
    check(miss_ack == 1, "R7 slot reusable", 256'(miss_ack), 256'(1));
    fill(~pat, 0);
    fill(pat, 0);
    check(rd_valid == 0 && line_data == pat, "R7 clean fill", 256'(rd_valid), 256'(0));
    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      miss_valid = ($urandom % 4) != 0; miss_is_write = $urandom % 2;
      miss_word = 3'($urandom); miss_dest = 5'($urandom); miss_size = 2'($urandom);
      miss_off = 2'($urandom); miss_signed = 1'($urandom); miss_wdata = $urandom;
      fill_valid = ($urandom % 10) == 0;
      for (int k = 0; k < 8; k++) fill_line[k*32 +: 32] = $urandom;
    end
    @(negedge clk);
    miss_valid = 0; fill_valid = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule